// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight single-bit semaphore latches that a left port and a right port share. The latches are separate from any memory array. Each port has its own semaphore select, a memory chip enable, a write enable, an address bus, a write data bus and a read data bus. A port claims a semaphore by writing 0 and gives it up by writing 1. It learns whether it holds the semaphore by reading it: 0 means this side holds it, and 1 means it does not.

Each latch keeps a request flag for each side, as well as the current owner. When the owner releases a semaphore while the other side is waiting, the waiting side takes ownership on the same clock edge. If the owner releases with nobody waiting, the semaphore becomes free. When both sides claim a free semaphore in the same cycle, the left side wins and the right side's claim stays pending.

Each port has its own output register for read data. That register captures the semaphore value, copied onto every data bit, and holds it until the next read on that port. A write from the opposite port therefore cannot disturb a value that has already been captured.

Top module: `sem_bank`

## Requirements
- R1: The low 3 address bits select one of eight independent semaphores. All higher address bits are ignored during semaphore access.
- R2: A semaphore write uses only write data bit 0. A 0 requests the semaphore, and a 1 releases it or cancels a pending request. The other data bits have no effect.
- R3: When one side requests a free semaphore, that side reads 0 from it afterwards and the opposite side reads 1 at the same address.
- R4: While a semaphore is held, a 0 written by the non-owning side does not take it over. The owner keeps reading 0 and the other side keeps reading 1.
- R5: If the non-owner requested while the semaphore was held, ownership passes to it on the edge where the owner writes 1. Otherwise, including when the request was cancelled by writing 1, both sides read 1 after the release.
- R6: A read access (select 1, chip enable 0, write enable 0) loads the port's output register with the semaphore value on every data bit: 8'h00 or 8'hFF. The new value is visible from the clock edge that ends the read cycle.
- R7: The output register captures the state as it was before that edge. It holds its value between reads, even when the other port writes in the same cycle or afterwards.
- R8: When both sides request the same free semaphore in the same cycle, the left side wins. The right side's request stays pending, so the right side gains ownership when the left side releases.
- R9: Reset makes all semaphores free with no pending requests, and sets both read registers to all ones.
- R10: An access is ignored when its memory chip enable is 1 or its select is 0. It causes no write and does not update the read register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| left_sel | input | 1 | Left semaphore select |
| left_mem_en | input | 1 | Left memory chip enable; when 1, the semaphore access is ignored |
| left_we | input | 1 | Left write enable (1 = write, 0 = read) |
| left_addr | input | ADDR_W (13) | Left address; low 3 bits pick the semaphore |
| left_wdata | input | DATA_W (8) | Left write data; only bit 0 is used |
| left_rdata | output | DATA_W (8) | Left registered read data |
| right_sel | input | 1 | Right semaphore select |
| right_mem_en | input | 1 | Right memory chip enable; when 1, the semaphore access is ignored |
| right_we | input | 1 | Right write enable (1 = write, 0 = read) |
| right_addr | input | ADDR_W (13) | Right address; low 3 bits pick the semaphore |
| right_wdata | input | DATA_W (8) | Right write data; only bit 0 is used |
| right_rdata | output | DATA_W (8) | Right registered read data |

## Verification
The bench covers four groups of cases:

- **Handoff.** A right-side claim waits on a held semaphore, then the owner releases. A design that dropped the waiting claim would show both sides reading FF instead of the right side reading 00.
- **Tie and cancel.** A same-cycle tie must go to the left side with the right side queued. A cancelled request must leave the semaphore free. A wrong design would either grant both sides, or hand the semaphore to a side that had already withdrawn.
- **Read and write in one cycle.** The bench reads on one port while the other port releases in the same cycle. A read register that followed live state would then flip with no read having taken place.
- **Ignored inputs.** Every vector carries junk in the upper address and data bits, and some accesses arrive with the chip enable asserted. A design that decoded those inputs would claim the wrong latch or take a forbidden write.

// File: rtl/sem_pkg.sv
package sem_pkg;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } sem_owner_t;

   localparam int SEM_COUNT_DEF = 8;
   localparam int SEM_ADDR_W_DEF = 13;
   localparam int SEM_DATA_W_DEF = 8;

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
   parameter int NUM_SEM = 8,
   parameter int SEM_AW  = 3,
   parameter int ADDR_W  = 13,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic               mem_en,
   input  logic               we,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SEM-1:0] wr_stb,
   output logic               wr_bit,
   output logic               rd_en,
   output logic [SEM_AW-1:0]  rd_idx
);

   logic              access;
   logic [SEM_AW-1:0] idx;
   logic              unused_hi_bits;

   assign access = sel & ~mem_en;
   assign idx    = addr[SEM_AW-1:0];
   assign rd_en  = access & ~we;
   assign rd_idx = idx;
   assign wr_bit = wdata[0];

   // Upper address and data bits take no part in a semaphore access.
   assign unused_hi_bits = ^{addr[ADDR_W-1:SEM_AW], wdata[DATA_W-1:1]};

   for (genvar g = 0; g < NUM_SEM; g++) begin : g_stb
      assign wr_stb[g] = access & we & (idx == SEM_AW'(g));
   end

   // R1
   stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb));

   // R10
   stb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en || !sel) |-> (wr_stb == '0 && !rd_en));

endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic l_wr,
   input  logic l_bit,
   input  logic r_wr,
   input  logic r_bit,
   output logic l_val,
   output logic r_val
);

   sem_owner_t owner_q, owner_d;
   logic       lreq_q, rreq_q;
   logic       lreq_d, rreq_d;

   always_comb begin
      lreq_d = l_wr ? ~l_bit : lreq_q;
      rreq_d = r_wr ? ~r_bit : rreq_q;
      owner_d = OWN_NONE;
      unique case (owner_q)
         OWN_RIGHT: begin
            if (rreq_d)      owner_d = OWN_RIGHT;
            else if (lreq_d) owner_d = OWN_LEFT;
         end
         default: begin
            // Free or held by the left side: the left claim has priority.
            if (lreq_d)      owner_d = OWN_LEFT;
            else if (rreq_d) owner_d = OWN_RIGHT;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_NONE;
         lreq_q  <= 1'b0;
         rreq_q  <= 1'b0;
      end else begin
         owner_q <= owner_d;
         lreq_q  <= lreq_d;
         rreq_q  <= rreq_d;
      end
   end

   assign l_val = (owner_q != OWN_LEFT);
   assign r_val = (owner_q != OWN_RIGHT);

   // R3
   grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_NONE && l_wr && !l_bit) |=> (!l_val && r_val));

   // R4
   keep_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_LEFT && r_wr && !r_bit && !(l_wr && l_bit)) |=> (!l_val && r_val));

   // R5
   handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_LEFT && rreq_q && l_wr && l_bit && !r_wr) |=> (owner_q == OWN_RIGHT));

   // R5
   free_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_NONE) |-> (!lreq_q && !rreq_q));

   // R8
   tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_NONE && l_wr && !l_bit && r_wr && !r_bit) |=> (owner_q == OWN_LEFT && rreq_q));

endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
   parameter int NUM_SEM = 8,
   parameter int SEM_AW  = 3,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [SEM_AW-1:0]  rd_idx,
   input  logic [NUM_SEM-1:0] vals,
   output logic [DATA_W-1:0]  rdata
);

   logic sel_val;

   assign sel_val = vals[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '1;
      else if (rd_en) rdata <= {DATA_W{sel_val}};
   end

   // R7
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   // R6
   read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rdata == {DATA_W{$past(vals[rd_idx])}}));

   // R6
   read_replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata == '0) || (rdata == '1));

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NUM_SEM = sem_pkg::SEM_COUNT_DEF,
   parameter int ADDR_W  = sem_pkg::SEM_ADDR_W_DEF,
   parameter int DATA_W  = sem_pkg::SEM_DATA_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              left_sel,
   input  logic              left_mem_en,
   input  logic              left_we,
   input  logic [ADDR_W-1:0] left_addr,
   input  logic [DATA_W-1:0] left_wdata,
   output logic [DATA_W-1:0] left_rdata,
   input  logic              right_sel,
   input  logic              right_mem_en,
   input  logic              right_we,
   input  logic [ADDR_W-1:0] right_addr,
   input  logic [DATA_W-1:0] right_wdata,
   output logic [DATA_W-1:0] right_rdata
);

   localparam int SEM_AW = $clog2(NUM_SEM);

   if (NUM_SEM < 2 || NUM_SEM != (1 << SEM_AW)) begin : g_bad_count
      $error("sem_bank: NUM_SEM must be a power of two of at least 2");
   end
   if (ADDR_W <= SEM_AW) begin : g_bad_addr
      $error("sem_bank: ADDR_W must exceed the semaphore index width");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("sem_bank: DATA_W must be at least 2");
   end

   logic [NUM_SEM-1:0] l_stb, r_stb;
   logic               l_bit, r_bit;
   logic               l_rd, r_rd;
   logic [SEM_AW-1:0]  l_idx, r_idx;
   logic [NUM_SEM-1:0] l_vals, r_vals;

   sem_port_dec #(.NUM_SEM(NUM_SEM), .SEM_AW(SEM_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ldec (
      .clk(clk), .rst_n(rst_n),
      .sel(left_sel), .mem_en(left_mem_en), .we(left_we),
      .addr(left_addr), .wdata(left_wdata),
      .wr_stb(l_stb), .wr_bit(l_bit), .rd_en(l_rd), .rd_idx(l_idx)
   );

   sem_port_dec #(.NUM_SEM(NUM_SEM), .SEM_AW(SEM_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdec (
      .clk(clk), .rst_n(rst_n),
      .sel(right_sel), .mem_en(right_mem_en), .we(right_we),
      .addr(right_addr), .wdata(right_wdata),
      .wr_stb(r_stb), .wr_bit(r_bit), .rd_en(r_rd), .rd_idx(r_idx)
   );

   for (genvar s = 0; s < NUM_SEM; s++) begin : g_cell
      sem_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .l_wr(l_stb[s]), .l_bit(l_bit),
         .r_wr(r_stb[s]), .r_bit(r_bit),
         .l_val(l_vals[s]), .r_val(r_vals[s])
      );
   end

   sem_read_reg #(.NUM_SEM(NUM_SEM), .SEM_AW(SEM_AW), .DATA_W(DATA_W)) u_lrd (
      .clk(clk), .rst_n(rst_n), .rd_en(l_rd), .rd_idx(l_idx),
      .vals(l_vals), .rdata(left_rdata)
   );

   sem_read_reg #(.NUM_SEM(NUM_SEM), .SEM_AW(SEM_AW), .DATA_W(DATA_W)) u_rrd (
      .clk(clk), .rst_n(rst_n), .rd_en(r_rd), .rd_idx(r_idx),
      .vals(r_vals), .rdata(right_rdata)
   );

   // R3
   no_dual_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_vals | r_vals) == '1);

endmodule

// File: tb/tb_sem_bank.sv
`timescale 1ns/1ps
module tb_sem_bank;

   localparam int ADDR_W = 13;
   localparam int DATA_W = 8;
   localparam logic [1:0] OP_I = 2'd0;
   localparam logic [1:0] OP_W = 2'd1;
   localparam logic [1:0] OP_R = 2'd2;
   localparam int NVEC = 19;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic left_sel, left_mem_en, left_we, right_sel, right_mem_en, right_we;
   logic [ADDR_W-1:0] left_addr, right_addr;
   logic [DATA_W-1:0] left_wdata, right_wdata, left_rdata, right_rdata;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sem_bank dut (
      .clk(clk), .rst_n(rst_n),
      .left_sel(left_sel), .left_mem_en(left_mem_en), .left_we(left_we),
      .left_addr(left_addr), .left_wdata(left_wdata), .left_rdata(left_rdata),
      .right_sel(right_sel), .right_mem_en(right_mem_en), .right_we(right_we),
      .right_addr(right_addr), .right_wdata(right_wdata), .right_rdata(right_rdata)
   );

   // Row: {lop[1:0], laddr[2:0], lbit, rop[1:0], raddr[2:0], rbit, exp_left, exp_right}
   // exp bit 1 -> rdata 8'hFF, 0 -> 8'h00, sampled one edge after the row is applied.
   localparam logic [13:0] VEC [NVEC] = '{
      {OP_W, 3'd3, 1'b0, OP_I, 3'd0, 1'b0, 1'b1, 1'b1}, // R3 left claims 3
      {OP_R, 3'd3, 1'b0, OP_R, 3'd3, 1'b0, 1'b0, 1'b1}, // R3 left 0, right 1
      {OP_I, 3'd0, 1'b0, OP_W, 3'd3, 1'b0, 1'b0, 1'b1}, // R4 right requests held 3
      {OP_R, 3'd3, 1'b0, OP_R, 3'd3, 1'b0, 1'b0, 1'b1}, // R4 left still owns
      {OP_W, 3'd3, 1'b1, OP_I, 3'd0, 1'b0, 1'b0, 1'b1}, // R5 left releases
      {OP_R, 3'd3, 1'b0, OP_R, 3'd3, 1'b0, 1'b1, 1'b0}, // R5 handoff to right
      {OP_I, 3'd0, 1'b0, OP_W, 3'd3, 1'b1, 1'b1, 1'b0}, // R5 right releases, none waiting
      {OP_R, 3'd3, 1'b0, OP_R, 3'd3, 1'b0, 1'b1, 1'b1}, // R5 both read 1
      {OP_W, 3'd5, 1'b0, OP_W, 3'd5, 1'b0, 1'b1, 1'b1}, // R8 tie on 5
      {OP_R, 3'd5, 1'b0, OP_R, 3'd5, 1'b0, 1'b0, 1'b1}, // R8 left wins
      {OP_W, 3'd5, 1'b1, OP_I, 3'd0, 1'b0, 1'b0, 1'b1}, // R8 left releases
      {OP_R, 3'd5, 1'b0, OP_R, 3'd5, 1'b0, 1'b1, 1'b0}, // R8 pending right now owns
      {OP_W, 3'd5, 1'b0, OP_I, 3'd0, 1'b0, 1'b1, 1'b0}, // R5 left waits on 5
      {OP_W, 3'd5, 1'b1, OP_I, 3'd0, 1'b0, 1'b1, 1'b0}, // R5 left cancels
      {OP_I, 3'd0, 1'b0, OP_W, 3'd5, 1'b1, 1'b1, 1'b0}, // R5 right releases
      {OP_R, 3'd5, 1'b0, OP_R, 3'd5, 1'b0, 1'b1, 1'b1}, // R5 cancelled: free
      {OP_W, 3'd0, 1'b0, OP_W, 3'd7, 1'b0, 1'b1, 1'b1}, // R1 claims on 0 and 7
      {OP_R, 3'd7, 1'b0, OP_R, 3'd0, 1'b0, 1'b1, 1'b1}, // R1 cross reads see 1
      {OP_R, 3'd0, 1'b0, OP_R, 3'd7, 1'b0, 1'b0, 1'b0}  // R1 own reads see 0
   };

   task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_port(input bit left, input logic [1:0] op, input logic [2:0] a,
                           input logic [DATA_W-1:0] d, input logic men, input logic [9:0] hi);
      if (left) begin
         left_sel = (op != OP_I); left_we = (op == OP_W); left_mem_en = men;
         left_addr = {hi, a}; left_wdata = d;
      end else begin
         right_sel = (op != OP_I); right_we = (op == OP_W); right_mem_en = men;
         right_addr = {hi, a}; right_wdata = d;
      end
   endtask

   task automatic idle();
      set_port(1'b1, OP_I, 3'd0, '0, 1'b0, '0);
      set_port(1'b0, OP_I, 3'd0, '0, 1'b0, '0);
   endtask

   initial begin
      #(20ns * 5000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 left reset", left_rdata, 8'hFF);
      check("R9 right reset", right_rdata, 8'hFF);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         logic [13:0] v;
         v = VEC[i];
         // R1 R2: junk in upper address and data bits
         set_port(1'b1, v[13:12], v[11:9], {7'(i * 13 + 5), v[8]}, 1'b0, 10'(i * 37 + 3));
         set_port(1'b0, v[7:6], v[5:3], {7'(i * 29 + 11), v[2]}, 1'b0, 10'(i * 91 + 7));
         @(negedge clk);
         check($sformatf("R1 vector %0d left", i), left_rdata, {DATA_W{v[1]}});
         check($sformatf("R1 vector %0d right", i), right_rdata, {DATA_W{v[0]}});
      end
      idle();

      // R7 read on right while left releases in the same cycle
      set_port(1'b1, OP_W, 3'd1, 8'h00, 1'b0, '0); @(negedge clk);
      idle();
      set_port(1'b0, OP_W, 3'd1, 8'h00, 1'b0, '0); @(negedge clk);
      set_port(1'b1, OP_W, 3'd1, 8'h01, 1'b0, '0);
      set_port(1'b0, OP_R, 3'd1, 8'h00, 1'b0, '0); @(negedge clk);
      check("R7 captured pre-edge value", right_rdata, 8'hFF);
      idle(); @(negedge clk);
      check("R7 holds without read", right_rdata, 8'hFF);
      check("R7 left unchanged by writes", left_rdata, 8'h00);
      set_port(1'b0, OP_R, 3'd1, 8'h00, 1'b0, '0); @(negedge clk);
      check("R5 handoff seen on read", right_rdata, 8'h00);
      idle();

      // R10 chip enable active: write and read ignored
      set_port(1'b1, OP_W, 3'd2, 8'h00, 1'b1, '0); @(negedge clk);
      set_port(1'b1, OP_R, 3'd2, 8'h00, 1'b0, '0);
      set_port(1'b0, OP_R, 3'd2, 8'h00, 1'b0, '0); @(negedge clk);
      check("R10 ignored write left", left_rdata, 8'hFF);
      check("R10 ignored write right", right_rdata, 8'hFF);
      idle();
      set_port(1'b1, OP_R, 3'd0, 8'h00, 1'b1, '0); @(negedge clk);
      check("R10 ignored read", left_rdata, 8'hFF);
      left_sel = 1'b0; left_we = 1'b1; left_addr = 13'd2; left_wdata = 8'h00; left_mem_en = 1'b0;
      @(negedge clk);
      set_port(1'b1, OP_R, 3'd2, 8'h00, 1'b0, '0); @(negedge clk);
      check("R10 unselected write ignored", left_rdata, 8'hFF);
      set_port(1'b1, OP_R, 3'd0, 8'h00, 1'b0, '0); @(negedge clk);
      check("R6 read owned 0", left_rdata, 8'h00);

      // R2 only bit 0 of write data counts
      set_port(1'b1, OP_W, 3'd4, 8'hFE, 1'b0, '0); @(negedge clk);
      set_port(1'b1, OP_R, 3'd4, 8'h00, 1'b0, '0); @(negedge clk);
      check("R2 FE requests", left_rdata, 8'h00);
      set_port(1'b1, OP_W, 3'd4, 8'h01, 1'b0, '0); @(negedge clk);
      set_port(1'b1, OP_R, 3'd4, 8'h00, 1'b0, '0); @(negedge clk);
      check("R2 01 releases", left_rdata, 8'hFF);
      idle();

      // R9 reset after ownership built up
      set_port(1'b1, OP_R, 3'd0, 8'h00, 1'b0, '0); @(negedge clk);
      idle();
      rst_n = 1'b0; @(negedge clk); @(negedge clk);
      check("R9 mid reset left", left_rdata, 8'hFF);
      check("R9 mid reset right", right_rdata, 8'hFF);
      rst_n = 1'b1; @(negedge clk);
      set_port(1'b1, OP_R, 3'd0, 8'h00, 1'b0, '0);
      set_port(1'b0, OP_R, 3'd7, 8'h00, 1'b0, '0); @(negedge clk);
      check("R9 semaphore 0 free", left_rdata, 8'hFF);
      check("R9 semaphore 7 free", right_rdata, 8'hFF);
      idle(); @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule